// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits beside a processor core and chooses which interrupt the core should service next. It gathers level requests from twenty-one vector slots, covering peripherals, a shared serial-port vector, an external maskable pin, a nonmaskable pin and several system traps. Each request is gated by the source's own enable where it has one and by one of the core's two global mask bits. The maskable-class sources obey the low mask bit. The nonmaskable pin obeys the nonmaskable mask bit. System traps obey neither.

The core pulses `insn_done` at each instruction boundary. The block samples the qualified requests only on that pulse and only when no service is already in progress. It then registers the winning slot's 16-bit vector address and emits a one-cycle take pulse. The vector is held steady until the core reports the vector fetch as complete. When the core reports that it has stacked its condition codes, the block asks it to raise the low mask bit. It also asks it to raise the nonmaskable mask bit, but only when the nonmaskable pin request is present in that cycle. The peripherals own their request flags, and the block never clears them.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `take_pulse`, `vec_valid`, `set_lo` and `set_nmi` are 0 and `vec_addr` is 16'h0000.
- R2: When `mask_lo` is 1, the serial slot (0), the peripheral slots (1..13, slot k uses `per_req[k-1]` and `per_en[k-1]`) and the external pin slot (14, `irq_req`) are never taken.
- R3: The nonmaskable pin slot (15, `nmi_req`) is blocked only by `mask_nmi`, is unaffected by `mask_lo`, and has no local enable.
- R4: The software trap (16), illegal opcode (17) and reset (20) slots ignore both mask bits. The watchdog (18) and clock-fail (19) slots also ignore both mask bits but need `wdog_en` or `clkfail_en` set.
- R5: The serial slot qualifies when any of its five conditions has its enable set: `ser_req[0]` with `ser_en[0]`, `ser_req[1]` with `ser_en[1]`, `ser_req[2]` with `ser_en[2]`, and both `ser_req[3]` and `ser_req[4]` with the shared `ser_en[3]`.
- R6: Among qualified slots the highest-numbered slot wins, and `vec_addr` = 16'hFFD6 + 2 × slot (reset gives FFFE, the serial slot gives FFD6).
- R7: Requests are sampled only on a clock edge where `insn_done` is 1 and no service is open. `take_pulse` is high for exactly the following cycle, and only if some slot qualified. Without `insn_done`, nothing is taken.
- R8: While `vec_valid` is 1, `vec_addr` does not change, and `insn_done` and new requests (including reset) start no service.
- R9: The first `ccr_stacked` of a service makes `set_lo` high for one cycle after that edge. `set_nmi` rises with it only if `nmi_req` was 1 at that edge.
- R10: `fetch_done` during a service drops `vec_valid` in the next cycle, and a later `insn_done` can then start a new service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mask_lo | input | 1 | Global mask for maskable-class sources |
| mask_nmi | input | 1 | Global mask for the nonmaskable pin |
| ser_req | input | 5 | Serial conditions: tx complete, tx empty, idle, overrun, rx full |
| ser_en | input | 4 | Serial enables; bit 3 is shared by overrun and rx full |
| per_req | input | NPER | Peripheral requests for slots 1..NPER |
| per_en | input | NPER | Peripheral local enables |
| irq_req | input | 1 | External maskable pin request |
| nmi_req | input | 1 | Nonmaskable pin request |
| soft_req | input | 1 | Software trap request |
| illop_req | input | 1 | Illegal opcode trap request |
| wdog_req | input | 1 | Watchdog failure request |
| wdog_en | input | 1 | Watchdog failure enable |
| clkfail_req | input | 1 | Clock monitor failure request |
| clkfail_en | input | 1 | Clock monitor enable |
| rst_req | input | 1 | Reset vector request |
| insn_done | input | 1 | Instruction boundary strobe |
| ccr_stacked | input | 1 | Core has stacked its condition codes |
| fetch_done | input | 1 | Core has fetched the vector |
| take_pulse | output | 1 | One-cycle take-interrupt pulse |
| vec_valid | output | 1 | A service is open and `vec_addr` is valid |
| vec_addr | output | 16 | Vector address of the chosen slot |
| set_lo | output | 1 | Request to set the low mask bit |
| set_nmi | output | 1 | Request to set the nonmaskable mask bit |

## Verification
A wrong gating or priority term appears as a wrong `vec_addr` or a missing `take_pulse` in the cycle right after the boundary strobe, so the bench compares that cycle against a reference priority model. A busy flag that is stuck or cleared too early shows up in two ways. Either the vector changes, or a second take pulse appears while the core forces higher-priority requests during flight. A bad stacked flag or nonmaskable-pending capture shows on `set_lo` or `set_nmi` one cycle after `ccr_stacked`.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    localparam int VEC_W    = 16;
    localparam int SER_N    = 5;
    localparam int SER_EN_N = 4;

    typedef struct packed {
        logic             busy;
        logic             stacked;
        logic             take;
        logic             set_lo;
        logic             set_nmi;
        logic [VEC_W-1:0] vec;
    } ivc_state_t;
endpackage

// File: rtl/irq_qualify.sv
module irq_qualify #(
    parameter int NPER  = 13,
    parameter int NSLOT = NPER + 8
) (
    input  logic                          mask_lo,
    input  logic                          mask_nmi,
    input  logic [irq_vec_pkg::SER_N-1:0] ser_req,
    input  logic [irq_vec_pkg::SER_EN_N-1:0] ser_en,
    input  logic [NPER-1:0]               per_req,
    input  logic [NPER-1:0]               per_en,
    input  logic                          irq_req,
    input  logic                          nmi_req,
    input  logic                          soft_req,
    input  logic                          illop_req,
    input  logic                          wdog_req,
    input  logic                          wdog_en,
    input  logic                          clkfail_req,
    input  logic                          clkfail_en,
    input  logic                          rst_req,
    output logic [NSLOT-1:0]              qual
);
    localparam int S_IRQ = NPER + 1;
    localparam int S_NMI = NPER + 2;
    localparam int S_SWT = NPER + 3;
    localparam int S_ILL = NPER + 4;
    localparam int S_WDG = NPER + 5;
    localparam int S_CLK = NPER + 6;
    localparam int S_RST = NPER + 7;

    logic [irq_vec_pkg::SER_N-1:0] ser_gate;
    // overrun and rx-full share the last enable
    assign ser_gate = {ser_en[3], ser_en[3], ser_en[2:0]};
    assign qual[0]  = !mask_lo && |(ser_req & ser_gate);

    for (genvar k = 0; k < NPER; k++) begin : g_per
        assign qual[k+1] = !mask_lo && per_req[k] && per_en[k];
    end

    assign qual[S_IRQ] = !mask_lo && irq_req;
    assign qual[S_NMI] = !mask_nmi && nmi_req;
    assign qual[S_SWT] = soft_req;
    assign qual[S_ILL] = illop_req;
    assign qual[S_WDG] = wdog_req && wdog_en;
    assign qual[S_CLK] = clkfail_req && clkfail_en;
    assign qual[S_RST] = rst_req;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N  = 21,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int k = 0; k < N; k++) begin
            if (req[k]) begin
                any = 1'b1;
                idx = IW'(k);
            end
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
    parameter int          NPER     = 13,
    parameter logic [15:0] VEC_BASE = 16'hFFD6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mask_lo,
    input  logic            mask_nmi,
    input  logic [4:0]      ser_req,
    input  logic [3:0]      ser_en,
    input  logic [NPER-1:0] per_req,
    input  logic [NPER-1:0] per_en,
    input  logic            irq_req,
    input  logic            nmi_req,
    input  logic            soft_req,
    input  logic            illop_req,
    input  logic            wdog_req,
    input  logic            wdog_en,
    input  logic            clkfail_req,
    input  logic            clkfail_en,
    input  logic            rst_req,
    input  logic            insn_done,
    input  logic            ccr_stacked,
    input  logic            fetch_done,
    output logic            take_pulse,
    output logic            vec_valid,
    output logic [15:0]     vec_addr,
    output logic            set_lo,
    output logic            set_nmi
);
    import irq_vec_pkg::*;

    localparam int NSLOT = NPER + 8;
    localparam int IDXW  = $clog2(NSLOT);

    logic [NSLOT-1:0] qual;
    logic             win_any;
    logic [IDXW-1:0]  win_idx;
    logic [VEC_W-1:0] win_vec;

    irq_qualify #(.NPER(NPER), .NSLOT(NSLOT)) u_qual (
        .mask_lo(mask_lo), .mask_nmi(mask_nmi),
        .ser_req(ser_req), .ser_en(ser_en),
        .per_req(per_req), .per_en(per_en),
        .irq_req(irq_req), .nmi_req(nmi_req),
        .soft_req(soft_req), .illop_req(illop_req),
        .wdog_req(wdog_req), .wdog_en(wdog_en),
        .clkfail_req(clkfail_req), .clkfail_en(clkfail_en),
        .rst_req(rst_req), .qual(qual)
    );

    irq_prio_enc #(.N(NSLOT), .IW(IDXW)) u_enc (
        .req(qual), .any(win_any), .idx(win_idx)
    );

    // two bytes per vector slot
    assign win_vec = VEC_BASE + VEC_W'({win_idx, 1'b0});

    ivc_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.take    = 1'b0;
        st_d.set_lo  = 1'b0;
        st_d.set_nmi = 1'b0;
        if (!st_q.busy) begin
            if (insn_done && win_any) begin
                st_d.busy    = 1'b1;
                st_d.stacked = 1'b0;
                st_d.take    = 1'b1;
                st_d.vec     = win_vec;
            end
        end else begin
            if (ccr_stacked && !st_q.stacked) begin
                st_d.stacked = 1'b1;
                st_d.set_lo  = 1'b1;
                st_d.set_nmi = nmi_req;
            end
            if (fetch_done) begin
                st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign take_pulse = st_q.take;
    assign vec_valid  = st_q.busy;
    assign vec_addr   = st_q.vec;
    assign set_lo     = st_q.set_lo;
    assign set_nmi    = st_q.set_nmi;
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        insn_done,
    input logic        ccr_stacked,
    input logic        take_pulse,
    input logic        vec_valid,
    input logic [15:0] vec_addr,
    input logic        set_lo,
    input logic        set_nmi
);
    p_take_at_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take_pulse |-> $past(insn_done));

    p_take_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take_pulse |=> !take_pulse);

    p_take_opens_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take_pulse |-> vec_valid);

    p_vec_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && $past(vec_valid)) |-> $stable(vec_addr));

    p_vec_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_addr[0] == 1'b0 && vec_addr >= 16'hFFD6));

    p_nmi_with_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_nmi |-> set_lo);

    p_lo_after_stack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_lo |-> ($past(ccr_stacked) && $past(vec_valid)));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .ccr_stacked(ccr_stacked),
    .take_pulse(take_pulse), .vec_valid(vec_valid), .vec_addr(vec_addr),
    .set_lo(set_lo), .set_nmi(set_nmi)
);

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;
    localparam int NPER = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mask_lo, mask_nmi;
    logic [4:0] ser_req;
    logic [3:0] ser_en;
    logic [NPER-1:0] per_req, per_en;
    logic irq_req, nmi_req, soft_req, illop_req, wdog_req, wdog_en;
    logic clkfail_req, clkfail_en, rst_req, insn_done, ccr_stacked, fetch_done;
    logic take_pulse, vec_valid, set_lo, set_nmi;
    logic [15:0] vec_addr;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    irq_vector_ctrl #(.NPER(NPER)) u0 (.*);

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int ref_slot();
        int s = -1;
        if (!mask_lo && |(ser_req & {ser_en[3], ser_en[3], ser_en[2:0]})) s = 0;
        for (int k = 0; k < NPER; k++)
            if (!mask_lo && per_req[k] && per_en[k]) s = k + 1;
        if (!mask_lo && irq_req) s = 14;
        if (!mask_nmi && nmi_req) s = 15;
        if (soft_req) s = 16;
        if (illop_req) s = 17;
        if (wdog_req && wdog_en) s = 18;
        if (clkfail_req && clkfail_en) s = 19;
        if (rst_req) s = 20;
        return s;
    endfunction

    task automatic clear_all();
        mask_lo = 0; mask_nmi = 0; ser_req = '0; ser_en = '0;
        per_req = '0; per_en = '0; irq_req = 0; nmi_req = 0; soft_req = 0;
        illop_req = 0; wdog_req = 0; wdog_en = 0; clkfail_req = 0;
        clkfail_en = 0; rst_req = 0;
    endtask

    // called at a negedge with requests set; runs one full service
    task automatic service(input string tag);
        int exp_s;
        logic [15:0] exp_v;
        logic save_rst, exp_nmi;
        exp_s = ref_slot();
        insn_done = 1;
        @(negedge clk);
        insn_done = 0;
        if (exp_s < 0) begin
            chk({31'd0, take_pulse}, 0, {tag, " R7 no take"});
            chk({31'd0, vec_valid}, 0, {tag, " R7 idle"});
            return;
        end
        exp_v = 16'hFFD6 + 16'(2 * exp_s);
        chk({31'd0, take_pulse}, 1, {tag, " R7 take"});
        chk({31'd0, vec_valid}, 1, {tag, " R8 valid"});
        chk({16'd0, vec_addr}, {16'd0, exp_v}, {tag, " R6 vector"});
        // R8: disturb during flight
        save_rst = rst_req;
        rst_req = 1; insn_done = 1;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk({16'd0, vec_addr}, {16'd0, exp_v}, {tag, " R8 frozen"});
            chk({31'd0, take_pulse}, 0, {tag, " R8 no retake"});
        end
        rst_req = save_rst; insn_done = 0;
        exp_nmi = nmi_req;
        ccr_stacked = 1;
        @(negedge clk);
        ccr_stacked = 0;
        chk({31'd0, set_lo}, 1, {tag, " R9 set_lo"});
        chk({31'd0, set_nmi}, {31'd0, exp_nmi}, {tag, " R9 set_nmi"});
        @(negedge clk);
        chk({31'd0, set_lo}, 0, {tag, " R9 single"});
        fetch_done = 1;
        @(negedge clk);
        fetch_done = 0;
        chk({31'd0, vec_valid}, 0, {tag, " R10 release"});
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        clear_all();
        insn_done = 0; ccr_stacked = 0; fetch_done = 0;
        repeat (3) @(negedge clk);
        // R1
        chk({31'd0, take_pulse}, 0, "R1 take");
        chk({31'd0, vec_valid}, 0, "R1 valid");
        chk({16'd0, vec_addr}, 0, "R1 vec");
        chk({30'd0, set_lo, set_nmi}, 0, "R1 sets");
        rst_n = 1;
        @(negedge clk);

        // R7: requests without boundary strobe
        rst_req = 1; soft_req = 1;
        repeat (3) @(negedge clk);
        chk({31'd0, take_pulse}, 0, "R7 no strobe");
        chk({31'd0, vec_valid}, 0, "R7 no strobe valid");
        clear_all();

        // R2: low mask blocks maskable class
        mask_lo = 1; ser_req = '1; ser_en = '1; per_req = '1; per_en = '1; irq_req = 1;
        service("R2 masked");
        clear_all();

        // R3
        mask_lo = 1; nmi_req = 1; irq_req = 1;
        service("R3 nmi under lo mask");
        mask_nmi = 1;
        service("R3 nmi masked");
        clear_all();

        // R4
        mask_lo = 1; mask_nmi = 1; soft_req = 1;
        service("R4 soft trap");
        soft_req = 0; wdog_req = 1;
        service("R4 wdog disabled");
        wdog_en = 1;
        service("R4 wdog enabled");
        wdog_req = 0; clkfail_req = 1; clkfail_en = 1; illop_req = 1;
        service("R4 clkfail");
        clear_all();

        // R5: each serial condition alone
        for (int c = 0; c < 5; c++) begin
            clear_all();
            ser_req = 5'(1 << c);
            ser_en = 4'b0;
            service("R5 serial no enable");
            ser_en = (c >= 3) ? 4'b1000 : 4'(1 << c);
            service("R5 serial enabled");
        end
        clear_all();

        // R6: everything pending, reset wins
        ser_req = '1; ser_en = '1; per_req = '1; per_en = '1; irq_req = 1; nmi_req = 1;
        soft_req = 1; illop_req = 1; wdog_req = 1; wdog_en = 1;
        clkfail_req = 1; clkfail_en = 1; rst_req = 1;
        service("R6 all pending");
        clear_all();

        // random mix, R6/R9/R10
        for (int n = 0; n < 400; n++) begin
            mask_lo  = ($urandom % 4) == 0;
            mask_nmi = ($urandom % 3) == 0;
            ser_req  = 5'($urandom);
            ser_en   = 4'($urandom);
            for (int k = 0; k < NPER; k++) begin
                per_req[k] = ($urandom % 6) == 0;
                per_en[k]  = ($urandom % 2) == 0;
            end
            irq_req     = ($urandom % 6) == 0;
            nmi_req     = ($urandom % 6) == 0;
            soft_req    = ($urandom % 12) == 0;
            illop_req   = ($urandom % 12) == 0;
            wdog_req    = ($urandom % 10) == 0;
            wdog_en     = ($urandom % 2) == 0;
            clkfail_req = ($urandom % 10) == 0;
            clkfail_en  = ($urandom % 2) == 0;
            rst_req     = ($urandom % 25) == 0;
            service("R6 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule